// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block turns the control pins of a 5-bit, 1 dB-per-step attenuator into a registered attenuation state. A mode pin chooses the source. In serial mode a 6-bit shift register is loaded from a serial data pin and a slow serial clock. In parallel mode the source is five weighted control pins. Both sources pass through one shared transparent latch, which the latch-enable pin opens and closes. Holding latch enable high in parallel mode gives direct control, where the state follows the pins.

All pins are asynchronous to the system clock. They pass through two-flop synchronizers, and the serial clock is edge-detected in the system clock domain. A synchronous reset stands in for power-up: while reset is held, the state is loaded from strapped pins, so the attenuator leaves reset at a chosen setting. A sticky flag records any attempt to open the latch on a serial word whose final bit is not zero.

Top module: `step_atten_ctrl`

## Requirements
- R1: `ser_mode` low selects the parallel pins `par_bits` as the latch source; `ser_mode` high selects the upper five bits of the serial shift register. Serial traffic in parallel mode does not change the state.
- R2: The shift register is 6 bits wide. It shifts in `ser_data` on each synchronized rising edge of `ser_clk`, whatever the level of `lat_en`. The word is sent most significant bit first: 16 dB, 8 dB, 4 dB, 2 dB, 1 dB, and then a stop bit, which is the last bit in.
- R3: While the synchronized `lat_en` is high, the latch is transparent and `state` follows the selected source. While it is low, `state` holds its value.
- R4: In latched parallel use, changes on `par_bits` while `lat_en` is low have no effect. A high-then-low pulse on `lat_en` captures the new value.
- R5: If the latch is open in serial mode while the stop bit (shift register bit 0) is 1, `state` keeps its old value and `stop_err` is set. `stop_err` stays set until reset.
- R6: If reset is held with `ser_mode` high, `state` takes `par_bits`, and the shift register takes `par_bits` followed by a zero stop bit. Opening the latch without shifting therefore keeps that state.
- R7: If reset is held with `ser_mode` low and `lat_en` low, `state` comes from `boot_sel`, with `boot_sel[1]` as the MSB: 00 gives 0, 01 gives 8, 10 gives 16, 11 gives 31.
- R8: If reset is held with `ser_mode` low and `lat_en` high, `state` takes `par_bits` and `boot_sel` is ignored.
- R9: `atten_db` equals 16·state[4] + 8·state[3] + 4·state[2] + 2·state[1] + state[0].
- R10: A change on a control pin reaches `state` on the third rising `clk` edge after it. `ser_clk` must have a period of at least 8 `clk` periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up stand-in) |
| ser_mode | input | 1 | 1 = serial source, 0 = parallel source |
| par_bits | input | 5 | Parallel control bits; bit 4 = 16 dB ... bit 0 = 1 dB |
| ser_data | input | 1 | Serial data |
| ser_clk | input | 1 | Serial clock, rising edge shifts |
| lat_en | input | 1 | Latch enable, high = transparent |
| boot_sel | input | 2 | Reset-time preset select for parallel mode |
| state | output | 5 | Latched attenuation state bits |
| atten_db | output | 5 | Attenuation in dB (weighted sum) |
| stop_err | output | 1 | Sticky flag: latch opened on a nonzero stop bit |

## Verification
The bench sends serial words while the latch is closed and checks that the state does not move until a latch pulse arrives. A design that latched on every shift, or that ignored shifts while closed, fails at that point. A word with a 1 stop bit is opened into the latch: a design that accepted it would load the wrong state, and one that cleared the flag on the next valid word would lose the stickiness. Each of the three reset strap cases is exercised, including all four presets, so a swapped select order shows up as 8 and 16 exchanged. A sampled pin change is checked one edge before and on the edge it must appear, which catches a missing or extra synchronizer stage.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int CTRL_W      = 5;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int N      = 1,
  parameter int STAGES = atten_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] st [STAGES];

  // during reset every stage takes the raw pins, so no false edge at release
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= d;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/atten_shreg.sv
module atten_shreg #(
  parameter int W = atten_pkg::CTRL_W,
  localparam int SW = W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_raw,
  input  logic [W-1:0]  par_raw,
  input  logic          sclk_s,
  input  logic          sdata_s,
  output logic [SW-1:0] sr
);
  logic sclk_q;
  logic rise;

  assign rise = sclk_s & ~sclk_q;

  always_ff @(posedge clk) begin
    sclk_q <= sclk_s;
    if (rst) begin
      if (mode_raw) sr <= {par_raw, 1'b0};
      else          sr <= '0;
    end else if (rise) begin
      sr <= {sr[SW-2:0], sdata_s};
    end
  end

  // R2: no edge, no shift
  assert_no_edge_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(sr));
  // R2: last bit in lands at bit 0
  assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
    rise |=> sr[0] == $past(sdata_s));
endmodule

// File: rtl/atten_latch.sv
module atten_latch #(
  parameter int W = atten_pkg::CTRL_W,
  localparam int SW = W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_raw,
  input  logic          le_raw,
  input  logic [W-1:0]  par_raw,
  input  logic [1:0]    boot_raw,
  input  logic          mode_s,
  input  logic          le_s,
  input  logic [W-1:0]  par_s,
  input  logic [SW-1:0] sr,
  output logic [W-1:0]  state_q,
  output logic          err_q
);
  logic [W-1:0] src;
  logic [W-1:0] boot_val;

  assign src = mode_s ? sr[SW-1:1] : par_s;

  always_comb begin
    case (boot_raw)
      2'b00:   boot_val = '0;
      2'b01:   boot_val = W'(1) << (W - 2);
      2'b10:   boot_val = W'(1) << (W - 1);
      default: boot_val = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      if (mode_raw || le_raw) state_q <= par_raw;
      else                    state_q <= boot_val;
    end else if (le_s) begin
      if (mode_s && sr[0]) err_q   <= 1'b1;
      else                 state_q <= src;
    end
  end

  assert_closed_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !le_s |=> $stable(state_q));
  assert_par_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (le_s && !mode_s) |=> state_q == $past(par_s));
  assert_ser_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (le_s && mode_s && !sr[0]) |=> state_q == $past(sr[SW-1:1]));
  assert_bad_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (le_s && mode_s && sr[0]) |=> ($stable(state_q) && err_q));
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int W = atten_pkg::CTRL_W,
  localparam int SW   = W + 1,
  localparam int DB_W = $clog2(1 << W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_mode,
  input  logic [W-1:0]    par_bits,
  input  logic            ser_data,
  input  logic            ser_clk,
  input  logic            lat_en,
  input  logic [1:0]      boot_sel,
  output logic [W-1:0]    state,
  output logic [DB_W-1:0] atten_db,
  output logic            stop_err
);
  localparam int BUS_W = W + 4;

  logic [BUS_W-1:0] bus_s;
  logic             mode_s, le_s, sclk_s, sdata_s;
  logic [W-1:0]     par_s;
  logic [SW-1:0]    sr;

  atten_sync #(.N(BUS_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_mode, lat_en, ser_clk, ser_data, par_bits}),
    .q   (bus_s)
  );

  assign {mode_s, le_s, sclk_s, sdata_s, par_s} = bus_s;

  atten_shreg #(.W(W)) u_shreg (
    .clk      (clk),
    .rst      (rst),
    .mode_raw (ser_mode),
    .par_raw  (par_bits),
    .sclk_s   (sclk_s),
    .sdata_s  (sdata_s),
    .sr       (sr)
  );

  atten_latch #(.W(W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .mode_raw (ser_mode),
    .le_raw   (lat_en),
    .par_raw  (par_bits),
    .boot_raw (boot_sel),
    .mode_s   (mode_s),
    .le_s     (le_s),
    .par_s    (par_s),
    .sr       (sr),
    .state_q  (state),
    .err_q    (stop_err)
  );

  // R9: weighted sum of the latched bits, built as an adder chain
  logic [DB_W-1:0] part [W+1];
  assign part[0] = '0;
  for (genvar i = 0; i < W; i++) begin : g_wsum
    assign part[i+1] = part[i] + (state[i] ? DB_W'(1 << i) : DB_W'(0));
  end
  assign atten_db = part[W];
endmodule

// File: tb/tb_step_atten_ctrl.sv
module tb_step_atten_ctrl;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_mode = 1'b0;
  logic [4:0] par_bits = '0;
  logic       ser_data = 1'b0;
  logic       ser_clk  = 1'b0;
  logic       lat_en   = 1'b0;
  logic [1:0] boot_sel = '0;
  logic [4:0] state;
  logic [4:0] atten_db;
  logic       stop_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  step_atten_ctrl dut (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .par_bits(par_bits),
    .ser_data(ser_data), .ser_clk(ser_clk), .lat_en(lat_en),
    .boot_sel(boot_sel), .state(state), .atten_db(atten_db),
    .stop_err(stop_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  // pin history: index 0 = pins seen one edge ago, 1 = two edges ago, ...
  int         h_mode[3], h_le[3], h_sclk[3], h_sd[3], h_par[3];
  int         m_state, m_err, m_sr;
  bit         m_valid = 0;

  function automatic int wsum(input int v);
    int s = 0;
    int w = 16;
    for (int b = 4; b >= 0; b--) begin
      if ((v >> b) & 1) s += w;
      w = w / 2;
    end
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_err = 0;
      if (ser_mode) begin m_state = par_bits; m_sr = par_bits * 2; end
      else begin
        m_sr = 0;
        if (lat_en) m_state = par_bits;
        else case (boot_sel)
          2'd0: m_state = 0;
          2'd1: m_state = 8;
          2'd2: m_state = 16;
          default: m_state = 31;
        endcase
      end
      for (int i = 0; i < 3; i++) begin
        h_mode[i] = ser_mode; h_le[i] = lat_en; h_sclk[i] = ser_clk;
        h_sd[i] = ser_data; h_par[i] = par_bits;
      end
      m_valid = 1;
    end else begin
      int nsr;
      nsr = m_sr;
      if (h_sclk[1] == 1 && h_sclk[2] == 0) nsr = ((m_sr * 2) + h_sd[1]) % 64;
      if (h_le[1] == 1) begin
        if (h_mode[1] == 1) begin
          if (m_sr % 2 == 1) m_err = 1;
          else m_state = m_sr / 2;
        end else m_state = h_par[1];
      end
      m_sr = nsr;
      for (int i = 2; i > 0; i--) begin
        h_mode[i] = h_mode[i-1]; h_le[i] = h_le[i-1]; h_sclk[i] = h_sclk[i-1];
        h_sd[i] = h_sd[i-1]; h_par[i] = h_par[i-1];
      end
      h_mode[0] = ser_mode; h_le[0] = lat_en; h_sclk[0] = ser_clk;
      h_sd[0] = ser_data; h_par[0] = par_bits;
    end
  end

  always @(negedge clk) begin
    if (m_valid && !rst) begin
      chk("R3 model state", state, m_state);
      chk("R9 model atten", atten_db, wsum(m_state));
      chk("R5 model stop_err", stop_err, m_err);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input bit m, input bit le, input int p, input int b);
    @(negedge clk);
    ser_mode = m; lat_en = le; par_bits = 5'(p); boot_sel = 2'(b);
    rst = 1'b1;
    cyc(4);
    rst = 1'b0;
    cyc(4);
  endtask

  task automatic send_ser(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) begin
      ser_data = w[i];
      cyc(2);
      ser_clk = 1'b1;
      cyc(5);
      ser_clk = 1'b0;
      cyc(3);
    end
    cyc(4);
  endtask

  task automatic pulse_le();
    lat_en = 1'b1;
    cyc(6);
    lat_en = 1'b0;
    cyc(5);
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R6: serial power-up takes the parallel pins
    do_reset(1, 0, 22, 3);
    chk("R6 serial reset state", state, 22);
    chk("R9 atten after reset", atten_db, 22);
    chk("R5 flag clear after reset", stop_err, 0);
    pulse_le();
    chk("R6 open latch keeps preset", state, 22);
    chk("R6 zero stop from preset", stop_err, 0);
    // R2/R4: shifting with latch closed does not move the state
    send_ser(6'b010110);
    chk("R2 closed latch ignores shift", state, 22);
    pulse_le();
    chk("R2 msb-first word latched", state, 11);
    chk("R9 atten 11", atten_db, 11);

    // R8: parallel reset with latch open uses par_bits, not boot_sel
    do_reset(0, 1, 5, 3);
    chk("R8 direct reset state", state, 5);
    // R10: latency of a direct parallel change
    par_bits = 5'd19;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 not yet at second edge", state, 5);
    @(posedge clk); #1;
    chk("R10 visible at third edge", state, 19);
    cyc(2);
    // R1: serial traffic ignored in parallel mode
    send_ser(6'b111110);
    chk("R1 parallel ignores serial", state, 19);
    ser_mode = 1'b1;
    cyc(5);
    chk("R1 serial source selected", state, 31);
    lat_en = 1'b0; ser_mode = 1'b0;
    cyc(4);
    // R4: latched parallel
    par_bits = 5'd7;
    cyc(8);
    chk("R4 closed latch holds", state, 31);
    pulse_le();
    chk("R4 pulse captures", state, 7);

    // R7: four reset presets
    do_reset(0, 0, 9, 0); chk("R7 preset 00", state, 0);
    do_reset(0, 0, 9, 1); chk("R7 preset 01", state, 8);
    do_reset(0, 0, 9, 2); chk("R7 preset 10", state, 16);
    do_reset(0, 0, 9, 3); chk("R7 preset 11", state, 31);
    chk("R9 atten 31", atten_db, 31);

    // R5: bad stop bit
    do_reset(1, 0, 3, 0);
    send_ser(6'b000011);
    pulse_le();
    chk("R5 bad stop holds state", state, 3);
    chk("R5 bad stop sets flag", stop_err, 1);
    send_ser(6'b001000);
    pulse_le();
    chk("R5 good word after error", state, 4);
    chk("R5 flag sticky", stop_err, 1);

    cyc(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule